// File: doc/BRIEF.md
# Indirect-Pointer Parallel Bus Slave

This block is a byte-wide register slave for an asynchronous parallel bus with two address lines, an active-low chip select and active-low read and write strobes. The bus master reaches a byte memory only through a 16-bit pointer. It loads the pointer one byte at a time through two address ports, then reads or writes a data port that reaches the memory byte under the pointer. A mode register holds an auto-increment enable, so a single pointer load can be followed by a burst of data-port accesses at successive addresses.

The bus strobes and chip select come from another clock domain. They are resampled in the slave clock through a chain of synchronizer flops, and edges are detected on the resampled copies. Address and write data travel through the same chain, so they stay aligned with the strobes. Read data comes out on its own output, together with an output enable. The enable is high only while chip select and the read strobe are both seen low, which keeps the external data bus from being driven by both sides at once. The memory holds 2^MEM_AW bytes and is indexed by the low MEM_AW bits of the pointer. Higher pointer bits alias onto the same storage.

Top module: `idx_bus_slave`

## Requirements
- R1: The two address lines select a port: 0 is the mode register, 1 is the pointer high byte, 2 is the pointer low byte and 3 is the data port. The data port reaches the memory byte indexed by the low MEM_AW bits of the pointer (MEM_AW = 8 by default, so pointer 0xFFFF and pointer 0x00FF reach the same byte).
- R2: A write takes effect only on a rising edge of the write strobe while chip select is low. It uses the address and data that were present while the strobe was low. Toggling the write strobe while chip select is high changes nothing.
- R3: The read-data output enable is high exactly while chip select and the read strobe are both low, delayed by the two synchronizer clocks. While the enable is high, the data output carries the value of the selected port.
- R4: When mode bit 1 is set, the pointer advances by one after each data-port write and after each data-port read. The read case advances on the rising edge of the read strobe. The memory write uses the pointer value from before the advance.
- R5: A write to the pointer high-byte port replaces only pointer bits 15:8. A write to the low-byte port replaces only bits 7:0.
- R6: The pointer counts modulo 2^16: an advance from 0xFFFF gives 0x0000, and a carry from bit 7 propagates into the high byte.
- R7: A read of port 1 or port 2 returns the matching pointer byte. A read of port 0 returns the mode register (0x00 after reset).
- R8: Writing the mode register with bit 7 set triggers a software reset. One clock later, the mode register and the pointer are both zero and memory contents are kept. Bit 0 (indirect select) and bit 1 are stored as written.
- R9: With mode bit 1 clear, data-port accesses do not move the pointer. Reads of ports 0 to 2 never move it, and writes to them change it only as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slave clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Bus chip select, active low |
| rdN | input | 1 | Bus read strobe, active low |
| wrN | input | 1 | Bus write strobe, active low |
| busAddr | input | 2 | Port select |
| busDataIn | input | 8 | Write data from the master |
| busDataOut | output | 8 | Read data to the master |
| busDataOe | output | 1 | High while the slave drives read data |

## Verification
A data-port write under auto-increment commits the memory byte and advances the pointer in the same clock edge. The bench provokes this by setting the pointer to 0x00FE and bursting three writes across the low-byte carry, and by writing at 0xFFFF to force the wrap. It then reloads the pointer and reads the bytes back. This confirms that each byte landed at the pre-advance address and that the pointer reached 0x0101 and then 0x0000. A behavioural model that holds the pin history in its own shift queue predicts the output enable and read data on every clock, so any misplaced byte or pointer slip shows up both in the per-clock comparison and in the directed readbacks.

// File: rtl/idx_bus_pkg.sv
package idx_bus_pkg;

  localparam int BYTE_W = 8;
  localparam int PTR_W  = 2 * BYTE_W;

  localparam int MODE_INDIRECT_BIT = 0;
  localparam int MODE_AUTOINC_BIT  = 1;
  localparam int MODE_SWRST_BIT    = 7;

  typedef enum logic [1:0] {
    PORT_MODE   = 2'd0,
    PORT_PTR_HI = 2'd1,
    PORT_PTR_LO = 2'd2,
    PORT_DATA   = 2'd3
  } portSel_e;

  typedef struct packed {
    logic              csN;
    logic              rdN;
    logic              wrN;
    portSel_e          addr;
    logic [BYTE_W-1:0] data;
  } busSample_t;

  typedef struct packed {
    logic              wrMode;
    logic              wrPtrHi;
    logic              wrPtrLo;
    logic              wrData;
    logic              rdDataDone;
    logic [BYTE_W-1:0] wdata;
  } ctrlStrobe_t;

  localparam busSample_t BUS_IDLE = '{csN: 1'b1, rdN: 1'b1, wrN: 1'b1,
                                      addr: PORT_MODE, data: '0};

endpackage

// File: rtl/idx_bus_ctrl.sv
module idx_bus_ctrl
  import idx_bus_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        rdN,
  input  logic        wrN,
  input  portSel_e    addr,
  input  logic [7:0]  dataIn,
  output ctrlStrobe_t strb,
  output portSel_e    rdPort,
  output logic        rdActive
);

  localparam int LAST = SYNC_STAGES;

  busSample_t stg [LAST+1];
  busSample_t pinNow;

  assign pinNow = '{csN: csN, rdN: rdN, wrN: wrN, addr: addr, data: dataIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stg[0] <= BUS_IDLE;
    else       stg[0] <= pinNow;
  end

  for (genvar i = 1; i <= LAST; i++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stg[i] <= BUS_IDLE;
      else       stg[i] <= stg[i-1];
    end
  end

  busSample_t cur, prv;
  logic wrRise, rdRise;

  assign cur = stg[LAST-1];
  assign prv = stg[LAST];

  assign wrRise = cur.wrN && !prv.wrN && !prv.csN;
  assign rdRise = cur.rdN && !prv.rdN && !prv.csN;

  always_comb begin
    strb            = '0;
    strb.wdata      = prv.data;
    strb.wrMode     = wrRise && (prv.addr == PORT_MODE);
    strb.wrPtrHi    = wrRise && (prv.addr == PORT_PTR_HI);
    strb.wrPtrLo    = wrRise && (prv.addr == PORT_PTR_LO);
    strb.wrData     = wrRise && (prv.addr == PORT_DATA);
    strb.rdDataDone = rdRise && (prv.addr == PORT_DATA);
  end

  assign rdActive = !cur.csN && !cur.rdN;
  assign rdPort   = cur.addr;

  // R2: at most one access commits per clock
  a_r2_single_commit: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrMode, strb.wrPtrHi, strb.wrPtrLo, strb.wrData, strb.rdDataDone}));

  if (SYNC_STAGES == 2) begin : g_oe_chk
    // R3: enable only after both pins were seen low two clocks earlier
    a_r3_oe_from_pins: assert property (@(posedge clk) disable iff (!rstN)
      rdActive |-> (!$past(csN, 2) && !$past(rdN, 2)));
  end

endmodule

// File: rtl/idx_bus_dp.sv
module idx_bus_dp
  import idx_bus_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strb,
  input  portSel_e    rdPort,
  input  logic        rdActive,
  output logic [7:0]  rdData
);

  localparam int MEM_DEPTH = 1 << MEM_AW;

  logic [BYTE_W-1:0] modeReg;
  logic [PTR_W-1:0]  ptr;
  logic [BYTE_W-1:0] mem [MEM_DEPTH];
  logic [MEM_AW-1:0] memIdx;
  logic              swRst, autoInc, doStep;

  assign memIdx  = ptr[MEM_AW-1:0];
  assign swRst   = modeReg[MODE_SWRST_BIT];
  assign autoInc = modeReg[MODE_AUTOINC_BIT];
  assign doStep  = autoInc && (strb.wrData || strb.rdDataDone);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= '0;
      ptr     <= '0;
    end else if (swRst) begin
      modeReg <= '0;
      ptr     <= '0;
    end else begin
      if (strb.wrMode)  modeReg <= strb.wdata;
      if (strb.wrPtrHi) ptr[PTR_W-1:BYTE_W] <= strb.wdata;
      if (strb.wrPtrLo) ptr[BYTE_W-1:0] <= strb.wdata;
      if (doStep)       ptr <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!swRst && strb.wrData) mem[memIdx] <= strb.wdata;
  end

  always_comb begin
    rdData = '0;
    if (rdActive) begin
      unique case (rdPort)
        PORT_MODE:   rdData = modeReg;
        PORT_PTR_HI: rdData = ptr[PTR_W-1:BYTE_W];
        PORT_PTR_LO: rdData = ptr[BYTE_W-1:0];
        PORT_DATA:   rdData = mem[memIdx];
        default:     rdData = '0;
      endcase
    end
  end

  // R4: an auto-increment data access steps the pointer by exactly one
  a_r4_step_one: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrData && autoInc && !swRst) |=> (ptr == $past(ptr) + 16'd1));

  // R5: high-byte write leaves the low byte alone
  a_r5_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrPtrHi && !swRst) |=> (ptr[7:0] == $past(ptr[7:0])));

  // R8: software reset clears mode and pointer one clock later
  a_r8_swrst_clears: assert property (@(posedge clk) disable iff (!rstN)
    swRst |=> (modeReg == 8'h00 && ptr == 16'h0000));

  // R9: no pointer movement without a pointer write or an auto-increment access
  a_r9_ptr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!swRst && !strb.wrPtrHi && !strb.wrPtrLo &&
     !(autoInc && (strb.wrData || strb.rdDataDone))) |=> $stable(ptr));

endmodule

// File: rtl/idx_bus_slave.sv
module idx_bus_slave
  import idx_bus_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MEM_AW      = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       rdN,
  input  logic       wrN,
  input  logic [1:0] busAddr,
  input  logic [7:0] busDataIn,
  output logic [7:0] busDataOut,
  output logic       busDataOe
);

  ctrlStrobe_t strb;
  portSel_e    rdPort;
  logic        rdActive;

  idx_bus_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .csN      (csN),
    .rdN      (rdN),
    .wrN      (wrN),
    .addr     (portSel_e'(busAddr)),
    .dataIn   (busDataIn),
    .strb     (strb),
    .rdPort   (rdPort),
    .rdActive (rdActive)
  );

  idx_bus_dp #(.MEM_AW(MEM_AW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .rdPort   (rdPort),
    .rdActive (rdActive),
    .rdData   (busDataOut)
  );

  assign busDataOe = rdActive;

endmodule

// File: tb/sim_idx_bus_slave.sv
module sim_idx_bus_slave;

  localparam int MEM_AW = 8;

  typedef struct packed {
    logic       cs;
    logic       rd;
    logic       wr;
    logic [1:0] a;
    logic [7:0] d;
  } pinSnap_t;

  localparam pinSnap_t IDLE = '{cs: 1'b1, rd: 1'b1, wr: 1'b1, a: 2'd0, d: 8'd0};

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busDataIn = 8'd0;
  logic [7:0] busDataOut;
  logic       busDataOe;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  idx_bus_slave #(.SYNC_STAGES(2), .MEM_AW(MEM_AW)) u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN),
    .busAddr(busAddr), .busDataIn(busDataIn),
    .busDataOut(busDataOut), .busDataOe(busDataOe)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  pinSnap_t   h0 = IDLE, h1 = IDLE, h2 = IDLE, h3 = IDLE;
  logic [7:0] mMode = 8'h00;
  logic [15:0] mPtr = 16'h0000;
  logic [7:0] mMem [int];

  initial begin
    forever begin
      @(posedge clk);
      if (!rstN) begin
        h0 = IDLE; h1 = IDLE; h2 = IDLE; h3 = IDLE;
        mMode = 8'h00; mPtr = 16'h0000;
      end else begin
        h3 = h2; h2 = h1; h1 = h0;
        h0 = '{cs: csN, rd: rdN, wr: wrN, a: busAddr, d: busDataIn};
        if (mMode[7]) begin
          mMode = 8'h00; mPtr = 16'h0000;
        end else if (!h3.cs && h2.wr && !h3.wr) begin
          case (h3.a)
            2'd0: mMode = h3.d;
            2'd1: mPtr[15:8] = h3.d;
            2'd2: mPtr[7:0] = h3.d;
            default: begin
              mMem[int'(mPtr[MEM_AW-1:0])] = h3.d;
              if (mMode[1]) mPtr = mPtr + 16'd1;
            end
          endcase
        end else if (!h3.cs && h2.rd && !h3.rd && h3.a == 2'd3 && mMode[1]) begin
          mPtr = mPtr + 16'd1;
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (rstN) begin
        logic expOe;
        expOe = !h1.cs && !h1.rd;
        check("R3 oe", {15'd0, busDataOe}, {15'd0, expOe});
        if (expOe) begin
          case (h1.a)
            2'd0: check("R7 mode", {8'd0, busDataOut}, {8'd0, mMode});
            2'd1: check("R5 ptrhi", {8'd0, busDataOut}, {8'd0, mPtr[15:8]});
            2'd2: check("R5 ptrlo", {8'd0, busDataOut}, {8'd0, mPtr[7:0]});
            default:
              if (mMem.exists(int'(mPtr[MEM_AW-1:0])))
                check("R1 data", {8'd0, busDataOut}, {8'd0, mMem[int'(mPtr[MEM_AW-1:0])]});
          endcase
        end
      end
    end
  end

  // ---------------- bus tasks ----------------
  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic busWrite(logic [1:0] a, logic [7:0] d);
    @(posedge clk); #5;
    busAddr = a; busDataIn = d; csN = 1'b0;
    @(posedge clk); #5; wrN = 1'b0;
    repeat (3) @(posedge clk);
    #5 wrN = 1'b1;
    @(posedge clk); #5 csN = 1'b1;
    idle(5);
  endtask

  task automatic busRead(logic [1:0] a, output logic [7:0] v);
    @(posedge clk); #5;
    busAddr = a; csN = 1'b0; rdN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    v = busDataOut;
    @(posedge clk); #5;
    csN = 1'b1; rdN = 1'b1;
    idle(5);
  endtask

  task automatic setPtr(logic [15:0] p);
    busWrite(2'd1, p[15:8]);
    busWrite(2'd2, p[7:0]);
  endtask

  task automatic finish;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #4_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish();
  end

  // ---------------- directed sequence ----------------
  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #5 rstN = 1'b1;
    idle(3);

    // reset state
    check("R3 reset oe", {15'd0, busDataOe}, 16'd0);
    busRead(2'd0, v); check("R7 reset mode", {8'd0, v}, 16'h00);
    busRead(2'd1, v); check("R7 reset ptrhi", {8'd0, v}, 16'h00);
    busRead(2'd2, v); check("R7 reset ptrlo", {8'd0, v}, 16'h00);

    // mode with indirect select and auto-increment
    busWrite(2'd0, 8'h03);
    busRead(2'd0, v); check("R8 mode stored", {8'd0, v}, 16'h03);

    // pointer byte ports
    setPtr(16'h1234);
    busRead(2'd1, v); check("R7 ptrhi", {8'd0, v}, 16'h12);
    busRead(2'd2, v); check("R7 ptrlo", {8'd0, v}, 16'h34);
    busWrite(2'd1, 8'h56);
    busRead(2'd2, v); check("R5 lo kept", {8'd0, v}, 16'h34);
    busRead(2'd1, v); check("R5 hi set", {8'd0, v}, 16'h56);

    // burst write across the low-byte carry
    setPtr(16'h00FE);
    busWrite(2'd3, 8'hAA);
    busWrite(2'd3, 8'hBB);
    busWrite(2'd3, 8'hCC);
    busRead(2'd1, v); check("R6 carry hi", {8'd0, v}, 16'h01);
    busRead(2'd2, v); check("R4 after burst lo", {8'd0, v}, 16'h01);
    setPtr(16'h00FE);
    busRead(2'd3, v); check("R4 rd0", {8'd0, v}, 16'hAA);
    busRead(2'd3, v); check("R4 rd1", {8'd0, v}, 16'hBB);
    busRead(2'd3, v); check("R4 rd2", {8'd0, v}, 16'hCC);
    busRead(2'd2, v); check("R4 rd advance", {8'd0, v}, 16'h01);

    // wrap at 0xFFFF and aliasing of high pointer bits
    setPtr(16'hFFFF);
    busWrite(2'd3, 8'hDD);
    busRead(2'd1, v); check("R6 wrap hi", {8'd0, v}, 16'h00);
    busRead(2'd2, v); check("R6 wrap lo", {8'd0, v}, 16'h00);
    setPtr(16'h00FF);
    busRead(2'd3, v); check("R1 alias", {8'd0, v}, 16'hDD);

    // auto-increment off
    busWrite(2'd0, 8'h01);
    setPtr(16'h0010);
    busWrite(2'd3, 8'h77);
    busRead(2'd3, v); check("R9 data", {8'd0, v}, 16'h77);
    busRead(2'd3, v); check("R9 data again", {8'd0, v}, 16'h77);
    busRead(2'd2, v); check("R9 ptr held lo", {8'd0, v}, 16'h10);
    busRead(2'd1, v); check("R9 ptr held hi", {8'd0, v}, 16'h00);

    // write strobe with chip select high
    @(posedge clk); #5 busAddr = 2'd1; busDataIn = 8'hAB;
    @(posedge clk); #5 wrN = 1'b0;
    repeat (3) @(posedge clk);
    #5 wrN = 1'b1;
    idle(5);
    busRead(2'd1, v); check("R2 cs high ignored", {8'd0, v}, 16'h00);

    // software reset keeps memory
    busWrite(2'd0, 8'h83);
    busRead(2'd0, v); check("R8 mode cleared", {8'd0, v}, 16'h00);
    busRead(2'd2, v); check("R8 ptr cleared", {8'd0, v}, 16'h00);
    setPtr(16'h0010);
    busRead(2'd3, v); check("R8 memory kept", {8'd0, v}, 16'h77);

    idle(4);
    finish();
  end

endmodule